// File: doc/BRIEF.md
# Branch Checkpoint and Mask Recovery Unit

This unit tracks the unresolved branches of an out-of-order core so that a wrong guess can be undone at once, without waiting for the branch to reach the head of the reorder buffer. Each dispatching branch claims one of a fixed number of checkpoint slots and sets the matching bit of a one-hot branch mask. The slot records the redirect PC, the predictor repair data, the reorder-buffer and load/store-queue tail indices, a copy of the rename map and a copy of the free-register vector. Every instruction dispatched alongside copies the visible mask, so it knows which older branches it depends on.

When a branch resolves, the unit either releases its slot and broadcasts a one-bit clear so that every waiting entry drops that dependence, or it presents the saved state on its restore outputs and broadcasts a squash that covers the wrong branch and every younger branch still in flight. Branches may resolve in any order, and the bits they release can be used again in the very next cycle. The reorder buffer, reservation stations and map table are outside this unit and consume its broadcasts and restore outputs.

Top module: `brk_recover_unit`

## Requirements
- R1: After reset no slot is in use: `live_mask_o` is 0, and `squash_valid_o`, `clear_valid_o`, `rec_valid_o` and `br_grant_o` are low.
- R2: A dispatching branch (`br_valid_i` high) is given the lowest-numbered free slot; `br_tag_o` is the one-hot bit of that slot (bit i for slot i) and `br_grant_o` is high in the same cycle. From the next cycle that bit is set in `live_mask_o`.
- R3: When every slot is in use, a dispatching branch gets no grant, `br_stall_o` is high and `live_mask_o` is unchanged after the edge.
- R4: A resolve with `res_mispredict_i` low for a live one-hot tag raises `clear_valid_o` with `clear_mask_o` equal to that tag in the same cycle; `live_mask_o` drops the bit in that same cycle and the slot is free for a grant on the next cycle.
- R5: A mispredict resolve for a live tag raises `squash_valid_o` with `squash_mask_o` equal to that tag ORed with the tags of every live branch dispatched after it, and all those bits are absent from `live_mask_o` in the same cycle and after the edge.
- R6: During a mispredict resolve, `rec_valid_o` is high and the restore outputs carry the PC, predictor repair data, ROB tail, LSQ tail and map copy that were presented when that branch was granted.
- R7: A bit freed by a correct resolve is removed from the dependence record of every other slot, so a later mispredict of a branch that reuses the bit squashes only that branch and its own younger branches.
- R8: A branch that dispatches in the same cycle as a mispredict resolve is not granted: `br_grant_o` low, `br_stall_o` high, and no new bit appears after the edge.
- R9: The restored free vector `rec_freelist_o` equals the free vector captured at grant ORed with every `freed_i` vector presented from the grant cycle up to and including the resolve cycle.
- R10: A resolve whose tag is not live has no effect: no squash, clear or restore is signalled and `live_mask_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | A branch wants a checkpoint this cycle |
| br_pc_i | input | PC_W | Redirect PC saved for the branch |
| br_bpr_i | input | BPR_W | Predictor repair data saved for the branch |
| br_rob_tail_i | input | ROB_W | ROB tail index to restore |
| br_lsq_tail_i | input | LSQ_W | LSQ tail index to restore |
| br_map_i | input | ARCH_REGS*PREG_W | Rename map copy, entry k in bits k*PREG_W upward |
| br_freelist_i | input | PHYS_REGS | Free physical register vector, bit p = register p free |
| freed_i | input | PHYS_REGS | Registers released this cycle |
| br_grant_o | output | 1 | Checkpoint granted this cycle |
| br_stall_o | output | 1 | Branch present but not granted |
| br_tag_o | output | NUM_CKPT | One-hot tag of the granted slot |
| live_mask_o | output | NUM_CKPT | Mask that dispatching instructions copy |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_tag_i | input | NUM_CKPT | One-hot tag of the resolving branch |
| res_mispredict_i | input | 1 | The resolving branch was mispredicted |
| squash_valid_o | output | 1 | Squash broadcast valid |
| squash_mask_o | output | NUM_CKPT | Entries with any of these bits are squashed |
| clear_valid_o | output | 1 | Clear broadcast valid |
| clear_mask_o | output | NUM_CKPT | Bit to clear from every entry mask |
| rec_valid_o | output | 1 | Restore outputs valid |
| rec_pc_o | output | PC_W | Redirect PC |
| rec_bpr_o | output | BPR_W | Predictor repair data |
| rec_rob_tail_o | output | ROB_W | ROB tail to restore |
| rec_lsq_tail_o | output | LSQ_W | LSQ tail to restore |
| rec_map_o | output | ARCH_REGS*PREG_W | Map table to restore |
| rec_freelist_o | output | PHYS_REGS | Free vector to restore |

## Verification
The bench goes after nested mispredicts, where a unit that squashed only the resolving bit would leave younger branches holding slots that can never be freed. It reuses a bit released by a correct resolve and then mispredicts the new owner; a unit that kept stale dependence bits would wrongly squash an older, unrelated branch. It also collides a dispatch with a mispredict, where a careless unit would grant a slot that belongs to the squashed path, and checks that registers released after the checkpoint reappear in the restored free vector instead of leaking.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Kind of resolve seen in the current cycle, after checking the tag is live.
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_GOOD = 2'd1,
    RES_BAD  = 2'd2
  } res_kind_e;

endpackage

// File: rtl/brk_alloc.sv
module brk_alloc #(
  parameter int NUM_CKPT = 4
) (
  input  logic [NUM_CKPT-1:0] busy_i,
  output logic [NUM_CKPT-1:0] pick_o,
  output logic                any_free_o
);

  logic [NUM_CKPT:0] seen_free;

  assign seen_free[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CKPT; gi++) begin : g_pick
      assign pick_o[gi]       = ~busy_i[gi] & ~seen_free[gi];
      assign seen_free[gi+1]  = seen_free[gi] | ~busy_i[gi];
    end
  endgenerate

  assign any_free_o = seen_free[NUM_CKPT];

  // R2
  pick_onehot_chk: assert final ($onehot0(pick_o));

endmodule

// File: rtl/brk_slot.sv
module brk_slot #(
  parameter int NUM_CKPT  = 4,
  parameter int PC_W      = 16,
  parameter int BPR_W     = 8,
  parameter int ROB_W     = 5,
  parameter int LSQ_W     = 4,
  parameter int MAP_W     = 40,
  parameter int PHYS_REGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic                 live_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [BPR_W-1:0]     bpr_i,
  input  logic [ROB_W-1:0]     rob_i,
  input  logic [LSQ_W-1:0]     lsq_i,
  input  logic [MAP_W-1:0]     map_i,
  input  logic [PHYS_REGS-1:0] fl_i,
  input  logic [NUM_CKPT-1:0]  parent_i,
  input  logic [NUM_CKPT-1:0]  strip_i,
  input  logic [PHYS_REGS-1:0] freed_i,
  output logic [PC_W-1:0]      pc_o,
  output logic [BPR_W-1:0]     bpr_o,
  output logic [ROB_W-1:0]     rob_o,
  output logic [LSQ_W-1:0]     lsq_o,
  output logic [MAP_W-1:0]     map_o,
  output logic [PHYS_REGS-1:0] fl_o,
  output logic [NUM_CKPT-1:0]  parent_o
);

  logic [PC_W-1:0]      pc_q;
  logic [BPR_W-1:0]     bpr_q;
  logic [ROB_W-1:0]     rob_q;
  logic [LSQ_W-1:0]     lsq_q;
  logic [MAP_W-1:0]     map_q;
  logic [PHYS_REGS-1:0] fl_q,     fl_d;
  logic [NUM_CKPT-1:0]  parent_q, parent_d;
  logic                 fl_en;

  always_comb begin
    fl_en    = wr_i | live_i;
    fl_d     = wr_i ? (fl_i | freed_i) : (fl_q | freed_i);
    parent_d = wr_i ? parent_i : (parent_q & ~strip_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      bpr_q    <= '0;
      rob_q    <= '0;
      lsq_q    <= '0;
      map_q    <= '0;
      fl_q     <= '0;
      parent_q <= '0;
    end else begin
      if (wr_i) begin
        pc_q  <= pc_i;
        bpr_q <= bpr_i;
        rob_q <= rob_i;
        lsq_q <= lsq_i;
        map_q <= map_i;
      end
      if (fl_en) begin
        fl_q <= fl_d;
      end
      parent_q <= parent_d;
    end
  end

  assign pc_o     = pc_q;
  assign bpr_o    = bpr_q;
  assign rob_o    = rob_q;
  assign lsq_o    = lsq_q;
  assign map_o    = map_q;
  assign fl_o     = fl_q;
  assign parent_o = parent_q;

  // R9
  fl_keeps_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !wr_i) |=> ((fl_q & $past(freed_i)) == $past(freed_i)));

endmodule

// File: rtl/brk_recover_unit.sv
module brk_recover_unit
  import brk_pkg::*;
#(
  parameter int NUM_CKPT  = 4,
  parameter int PC_W      = 16,
  parameter int BPR_W     = 8,
  parameter int ROB_W     = 5,
  parameter int LSQ_W     = 4,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 32,
  parameter int PREG_W    = $clog2(PHYS_REGS),
  parameter int MAP_W     = ARCH_REGS * PREG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_valid_i,
  input  logic [PC_W-1:0]      br_pc_i,
  input  logic [BPR_W-1:0]     br_bpr_i,
  input  logic [ROB_W-1:0]     br_rob_tail_i,
  input  logic [LSQ_W-1:0]     br_lsq_tail_i,
  input  logic [MAP_W-1:0]     br_map_i,
  input  logic [PHYS_REGS-1:0] br_freelist_i,
  input  logic [PHYS_REGS-1:0] freed_i,
  output logic                 br_grant_o,
  output logic                 br_stall_o,
  output logic [NUM_CKPT-1:0]  br_tag_o,
  output logic [NUM_CKPT-1:0]  live_mask_o,
  input  logic                 res_valid_i,
  input  logic [NUM_CKPT-1:0]  res_tag_i,
  input  logic                 res_mispredict_i,
  output logic                 squash_valid_o,
  output logic [NUM_CKPT-1:0]  squash_mask_o,
  output logic                 clear_valid_o,
  output logic [NUM_CKPT-1:0]  clear_mask_o,
  output logic                 rec_valid_o,
  output logic [PC_W-1:0]      rec_pc_o,
  output logic [BPR_W-1:0]     rec_bpr_o,
  output logic [ROB_W-1:0]     rec_rob_tail_o,
  output logic [LSQ_W-1:0]     rec_lsq_tail_o,
  output logic [MAP_W-1:0]     rec_map_o,
  output logic [PHYS_REGS-1:0] rec_freelist_o
);

  logic [NUM_CKPT-1:0] mask_q, mask_d;
  logic [NUM_CKPT-1:0] pick;
  logic                any_free;
  logic [NUM_CKPT-1:0] hit_tag;
  logic [NUM_CKPT-1:0] younger;
  logic [NUM_CKPT-1:0] kill_bits;
  logic [NUM_CKPT-1:0] clr_bits;
  logic [NUM_CKPT-1:0] visible;
  logic                grant;
  res_kind_e           res_kind;

  logic [PC_W-1:0]      s_pc     [NUM_CKPT];
  logic [BPR_W-1:0]     s_bpr    [NUM_CKPT];
  logic [ROB_W-1:0]     s_rob    [NUM_CKPT];
  logic [LSQ_W-1:0]     s_lsq    [NUM_CKPT];
  logic [MAP_W-1:0]     s_map    [NUM_CKPT];
  logic [PHYS_REGS-1:0] s_fl     [NUM_CKPT];
  logic [NUM_CKPT-1:0]  s_parent [NUM_CKPT];

  brk_alloc #(.NUM_CKPT(NUM_CKPT)) alloc_i (
    .busy_i     (mask_q),
    .pick_o     (pick),
    .any_free_o (any_free)
  );

  // Resolve decode: only a tag that is live counts.
  always_comb begin
    hit_tag  = res_tag_i & mask_q;
    res_kind = RES_NONE;
    if (res_valid_i && (hit_tag != '0)) begin
      res_kind = res_mispredict_i ? RES_BAD : RES_GOOD;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CKPT; gi++) begin : g_slot
      // A live slot is younger than the resolving branch if it recorded that bit.
      assign younger[gi] = mask_q[gi] & ((s_parent[gi] & hit_tag) != '0);

      brk_slot #(
        .NUM_CKPT (NUM_CKPT),
        .PC_W     (PC_W),
        .BPR_W    (BPR_W),
        .ROB_W    (ROB_W),
        .LSQ_W    (LSQ_W),
        .MAP_W    (MAP_W),
        .PHYS_REGS(PHYS_REGS)
      ) slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (grant & pick[gi]),
        .live_i   (mask_q[gi]),
        .pc_i     (br_pc_i),
        .bpr_i    (br_bpr_i),
        .rob_i    (br_rob_tail_i),
        .lsq_i    (br_lsq_tail_i),
        .map_i    (br_map_i),
        .fl_i     (br_freelist_i),
        .parent_i (visible),
        .strip_i  (clr_bits | kill_bits),
        .freed_i  (freed_i),
        .pc_o     (s_pc[gi]),
        .bpr_o    (s_bpr[gi]),
        .rob_o    (s_rob[gi]),
        .lsq_o    (s_lsq[gi]),
        .map_o    (s_map[gi]),
        .fl_o     (s_fl[gi]),
        .parent_o (s_parent[gi])
      );
    end
  endgenerate

  // Next-state for the mask and the broadcasts.
  always_comb begin
    kill_bits = '0;
    clr_bits  = '0;
    if (res_kind == RES_BAD) begin
      kill_bits = hit_tag | younger;
    end
    if (res_kind == RES_GOOD) begin
      clr_bits = hit_tag;
    end
    visible = mask_q & ~kill_bits & ~clr_bits;
    grant   = br_valid_i & any_free & (res_kind != RES_BAD);
    mask_d  = visible | (grant ? pick : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  // Restore mux: one-hot select of the resolving slot.
  always_comb begin
    rec_pc_o       = '0;
    rec_bpr_o      = '0;
    rec_rob_tail_o = '0;
    rec_lsq_tail_o = '0;
    rec_map_o      = '0;
    rec_freelist_o = freed_i;
    for (int k = 0; k < NUM_CKPT; k++) begin
      if (hit_tag[k]) begin
        rec_pc_o       = rec_pc_o       | s_pc[k];
        rec_bpr_o      = rec_bpr_o      | s_bpr[k];
        rec_rob_tail_o = rec_rob_tail_o | s_rob[k];
        rec_lsq_tail_o = rec_lsq_tail_o | s_lsq[k];
        rec_map_o      = rec_map_o      | s_map[k];
        rec_freelist_o = rec_freelist_o | s_fl[k];
      end
    end
  end

  assign br_grant_o     = grant;
  assign br_stall_o     = br_valid_i & ~grant;
  assign br_tag_o       = grant ? pick : '0;
  assign live_mask_o    = visible;
  assign squash_valid_o = (res_kind == RES_BAD);
  assign squash_mask_o  = kill_bits;
  assign clear_valid_o  = (res_kind == RES_GOOD);
  assign clear_mask_o   = clr_bits;
  assign rec_valid_o    = (res_kind == RES_BAD);

  // R2
  grant_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_grant_o |=> ((mask_q & $past(br_tag_o)) == $past(br_tag_o)));

  // R2
  grant_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_grant_o |-> ($onehot(br_tag_o) && ((br_tag_o & mask_q) == '0)));

  // R5
  squash_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid_o |=> ((mask_q & $past(squash_mask_o)) == '0));

  // R4
  clear_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid_o |=> ((mask_q & $past(clear_mask_o)) == '0));

  // R8
  no_grant_on_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid_o |-> !br_grant_o);

  // R4
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clear_mask_o) && !(clear_valid_o && squash_valid_o));

endmodule

// File: tb/brk_recover_unit_tb.sv
module brk_recover_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int PC_W  = 16;
  localparam int BPR_W = 8;
  localparam int ROB_W = 5;
  localparam int LSQ_W = 4;
  localparam int AR    = 8;
  localparam int PR    = 32;
  localparam int PW    = 5;
  localparam int MW    = AR * PW;

  logic clk = 1'b0;
  logic rst_n;
  logic br_valid;
  logic [PC_W-1:0]  br_pc;
  logic [BPR_W-1:0] br_bpr;
  logic [ROB_W-1:0] br_rob;
  logic [LSQ_W-1:0] br_lsq;
  logic [MW-1:0]    br_map;
  logic [PR-1:0]    br_fl;
  logic [PR-1:0]    freed;
  logic             grant, stall;
  logic [N-1:0]     tag, live;
  logic             res_valid, res_bad;
  logic [N-1:0]     res_tag;
  logic             sq_v, cl_v, rec_v;
  logic [N-1:0]     sq_m, cl_m;
  logic [PC_W-1:0]  rec_pc;
  logic [BPR_W-1:0] rec_bpr;
  logic [ROB_W-1:0] rec_rob;
  logic [LSQ_W-1:0] rec_lsq;
  logic [MW-1:0]    rec_map;
  logic [PR-1:0]    rec_fl;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_recover_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .br_valid_i(br_valid), .br_pc_i(br_pc), .br_bpr_i(br_bpr),
    .br_rob_tail_i(br_rob), .br_lsq_tail_i(br_lsq), .br_map_i(br_map),
    .br_freelist_i(br_fl), .freed_i(freed),
    .br_grant_o(grant), .br_stall_o(stall), .br_tag_o(tag), .live_mask_o(live),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_mispredict_i(res_bad),
    .squash_valid_o(sq_v), .squash_mask_o(sq_m),
    .clear_valid_o(cl_v), .clear_mask_o(cl_m),
    .rec_valid_o(rec_v), .rec_pc_o(rec_pc), .rec_bpr_o(rec_bpr),
    .rec_rob_tail_o(rec_rob), .rec_lsq_tail_o(rec_lsq),
    .rec_map_o(rec_map), .rec_freelist_o(rec_fl)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    br_valid = 1'b0; br_pc = '0; br_bpr = '0; br_rob = '0; br_lsq = '0;
    br_map = '0; br_fl = '0; freed = '0;
    res_valid = 1'b0; res_tag = '0; res_bad = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [MW-1:0] map_of(input logic [4:0] s);
    return {AR{s}};
  endfunction

  // Presents a branch whose payload derives from pc and rob; returns grant and tag.
  task automatic dispatch(input logic [15:0] pc, input logic [4:0] rob,
                          input logic [PR-1:0] fl,
                          output logic g, output logic [N-1:0] t);
    br_valid = 1'b1; br_pc = pc; br_bpr = pc[7:0] ^ 8'h5A;
    br_rob = rob; br_lsq = rob[3:0] + 4'd1; br_map = map_of(rob); br_fl = fl;
    #1;
    g = grant; t = tag;
    step();
    br_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 live", live, 0);
    chk("R1 squash", sq_v, 0);
    chk("R1 clear", cl_v, 0);
    chk("R1 restore", rec_v, 0);
    chk("R1 grant", grant, 0);
  endtask

  task automatic t_fill();
    logic g; logic [N-1:0] t;
    do_reset();
    for (int i = 0; i < N; i++) begin
      dispatch(16'h1000 + 16'(i), 5'(i), '0, g, t);
      chk("R2 grant", g, 1);
      chk("R2 tag", t, 64'(1) << i);
    end
    chk("R2 live full", live, 4'hF);
    br_valid = 1'b1; #1;
    chk("R3 no grant", grant, 0);
    chk("R3 stall", stall, 1);
    step(); br_valid = 1'b0;
    chk("R3 mask kept", live, 4'hF);
  endtask

  task automatic t_good();
    logic g; logic [N-1:0] t;
    do_reset();
    for (int i = 0; i < 3; i++) dispatch(16'h2000 + 16'(i), 5'(i), '0, g, t);
    res_valid = 1'b1; res_tag = 4'b0010; res_bad = 1'b0; #1;
    chk("R4 clear valid", cl_v, 1);
    chk("R4 clear mask", cl_m, 4'b0010);
    chk("R4 no squash", sq_v, 0);
    chk("R4 live same cycle", live, 4'b0101);
    step(); idle();
    chk("R4 live after", live, 4'b0101);
    dispatch(16'h2100, 5'd9, '0, g, t);
    chk("R4 reuse tag", t, 4'b0010);
    chk("R4 live refill", live, 4'b0111);
  endtask

  task automatic t_nested();
    logic g; logic [N-1:0] t;
    do_reset();
    dispatch(16'hA000, 5'd3, '0, g, t);
    dispatch(16'hB000, 5'd7, '0, g, t);
    dispatch(16'hC000, 5'd11, '0, g, t);
    res_valid = 1'b1; res_tag = 4'b0010; res_bad = 1'b1; #1;
    chk("R5 squash valid", sq_v, 1);
    chk("R5 squash mask", sq_m, 4'b0110);
    chk("R5 live same cycle", live, 4'b0001);
    chk("R6 restore valid", rec_v, 1);
    chk("R6 pc", rec_pc, 16'hB000);
    chk("R6 bpr", rec_bpr, 8'h00 ^ 8'h5A);
    chk("R6 rob", rec_rob, 5'd7);
    chk("R6 lsq", rec_lsq, 4'd8);
    chk("R6 map", rec_map, map_of(5'd7));
    step(); idle();
    chk("R5 live after", live, 4'b0001);
    res_valid = 1'b1; res_tag = 4'b0100; res_bad = 1'b1; #1;
    chk("R10 no squash", sq_v, 0);
    chk("R10 no restore", rec_v, 0);
    chk("R10 no clear", cl_v, 0);
    step(); idle();
    chk("R10 live kept", live, 4'b0001);
  endtask

  task automatic t_strip();
    logic g; logic [N-1:0] t;
    do_reset();
    dispatch(16'h3000, 5'd1, '0, g, t);
    dispatch(16'h3100, 5'd2, '0, g, t);
    res_valid = 1'b1; res_tag = 4'b0001; res_bad = 1'b0;
    step(); idle();
    dispatch(16'h3200, 5'd4, '0, g, t);
    chk("R7 reused tag", t, 4'b0001);
    res_valid = 1'b1; res_tag = 4'b0001; res_bad = 1'b1; #1;
    chk("R7 squash only reuser", sq_m, 4'b0001);
    chk("R7 restore pc", rec_pc, 16'h3200);
    step(); idle();
    chk("R7 older survives", live, 4'b0010);
  endtask

  task automatic t_collide();
    logic g; logic [N-1:0] t;
    do_reset();
    dispatch(16'h4000, 5'd5, '0, g, t);
    br_valid = 1'b1; br_pc = 16'h4100;
    res_valid = 1'b1; res_tag = 4'b0001; res_bad = 1'b1; #1;
    chk("R8 no grant", grant, 0);
    chk("R8 stall", stall, 1);
    step(); idle();
    chk("R8 no new bit", live, 4'b0000);
  endtask

  task automatic t_freelist();
    logic g; logic [N-1:0] t;
    do_reset();
    freed = 32'h0000_0001;
    dispatch(16'h5000, 5'd6, 32'h0000_00F0, g, t);
    freed = 32'h0000_0100;
    step();
    freed = 32'h0000_0200;
    res_valid = 1'b1; res_tag = 4'b0001; res_bad = 1'b1; #1;
    chk("R9 merged free vector", rec_fl, 32'h0000_03F1);
    step(); idle();
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    t_reset();
    t_fill();
    t_good();
    t_nested();
    t_strip();
    t_collide();
    t_freelist();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule